// File: doc/BRIEF.md
# Swappable-Register PWM Timer

This block is a 16-bit up-counting timer driven by a prescaled clock-enable strobe. It holds two compare values: an 8-bit coarse value that is scaled by 256 counts, and a 16-bit fine value. In edge-aligned PWM mode one of them sets the waveform period and the other sets the duty. A swap select decides which does which. In timer/counter mode the counter and both compare flags keep running, but the pin is left undriven.

Both compare values and the swap select go into shadow registers. The shadows are reloaded only while reset is held and at the end of each period, so a write made partway through a period cannot shorten or glitch it. The mode, output-control, polarity and invert inputs act at once. Two one-clock flags report compare matches, one for each register. The fine flag also marks the period end when the fine value sets the period, and the coarse flag does so when the coarse value sets it.

Top module: `swap_pwm_timer`

## Requirements
- R1: While `rst` is high (synchronous, active high) the counter is held at 0, both flags are 0, and the shadows take the current `coarseReg`, `fineReg` and `swapSel`.
- R2: The counter advances by one only on a clock edge where `tick` is 1. With `tick` at 0 it holds its value.
- R3: With the swap shadow at 0 the period is coarse×256 counts, and a coarse value of 0 gives 65536 counts. The duty is the fine value in counts.
- R4: With the swap shadow at 1 the period is the fine value in counts, and a fine value of 0 gives 65536. The duty is coarse×256, and a coarse value of 0 gives a duty of 65536.
- R5: The waveform is at its active level while count < duty. So a duty of 0 never goes active, and a duty equal to or greater than the period stays active for the whole period.
- R6: With `activeHigh`=1 the active level is 1, and with 0 it is 0. `invertOut`=1 then flips the final waveform.
- R7: In PWM mode (`modeSel`=2'b10), `pinEn` is 1. The value of `outCtl` picks the pin level: 2'b10 gives the waveform, 2'b01 forces 1, and 2'b00 or 2'b11 force 0. These forced levels ignore polarity.
- R8: For any `modeSel` other than 2'b10 (timer/counter mode is 2'b11), counting and both flags behave as in PWM mode, while `pinEn` and `pwmOut` stay at 0.
- R9: `fineHit` pulses high for exactly one clock after a tick edge at which count+1 equals the fine value (0 read as 65536). `coarseHit` does the same for coarse×256 (0 read as 65536).
- R10: Changes to `coarseReg`, `fineReg` and `swapSel` take effect only when the counter wraps at the end of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from the prescaler |
| modeSel | input | 2 | 2'b10 PWM output, 2'b11 timer/counter |
| outCtl | input | 2 | 2'b10 waveform, 2'b01 force high, 2'b00/2'b11 force low |
| activeHigh | input | 1 | Active level of the waveform |
| invertOut | input | 1 | Inverts the final waveform |
| swapSel | input | 1 | 0: coarse sets period; 1: fine sets period |
| coarseReg | input | 8 | Coarse compare value, units of 256 counts |
| fineReg | input | 16 | Fine compare value in counts |
| pwmOut | output | 1 | Pin level |
| pinEn | output | 1 | Pin driven by the timer |
| fineHit | output | 1 | Fine compare match pulse |
| coarseHit | output | 1 | Coarse compare match pulse |

## Verification
The properties assume that reset is held for at least one clock at start-up. They also assume that `tick` is a level sampled at each edge, with no relation to the compare values. They allow the compare inputs to change at any time, because the shadows absorb such changes. The stimulus holds reset across two edges before each scenario and loads the configuration during that reset. It drives every input change at the falling edge, away from the active edge. Each waveform scenario starts from count 0, so the period, duty and flag positions measured from the release of reset are exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] MODE_PWM    = 2'b10;
  localparam logic [1:0] MODE_TIMER  = 2'b11;
  localparam logic [1:0] OUT_LOW     = 2'b00;
  localparam logic [1:0] OUT_HIGH    = 2'b01;
  localparam logic [1:0] OUT_WAVE    = 2'b10;
  localparam logic [1:0] OUT_LOW_ALT = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // count this edge
    logic wrap;     // period ends on this edge
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CRS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrStrobe_t       strobe,
  input  logic [CRS_W-1:0] coarseIn,
  input  logic [CNT_W-1:0] fineIn,
  input  logic             swapIn,
  output logic [CNT_W-1:0] count,
  output logic [CRS_W-1:0] coarseSh,
  output logic [CNT_W-1:0] fineSh,
  output logic             swapSh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      coarseSh <= coarseIn;
      fineSh   <= fineIn;
      swapSh   <= swapIn;
    end else if (strobe.advance) begin
      if (strobe.wrap) begin
        count    <= '0;
        coarseSh <= coarseIn;
        fineSh   <= fineIn;
        swapSh   <= swapIn;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CRS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       outCtl,
  input  logic             activeHigh,
  input  logic             invertOut,
  input  logic [CNT_W-1:0] count,
  input  logic [CRS_W-1:0] coarseSh,
  input  logic [CNT_W-1:0] fineSh,
  input  logic             swapSh,
  output tmrStrobe_t       strobe,
  output logic             pwmOut,
  output logic             pinEn,
  output logic             fineHit,
  output logic             coarseHit
);
  localparam int EXT_W = CNT_W + 1;
  localparam int SHIFT = CNT_W - CRS_W;
  localparam logic [EXT_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [EXT_W-1:0] coarseEff, fineEff, periodVal, dutyVal, countNext;
  logic             inDuty, waveLvl;

  // Zero codes stand for a full 2^CNT_W span
  always_comb begin
    coarseEff = (coarseSh == '0) ? FULL : (EXT_W'(coarseSh) << SHIFT);
    fineEff   = (fineSh == '0)   ? FULL : EXT_W'(fineSh);
    periodVal = swapSh ? fineEff   : coarseEff;
    dutyVal   = swapSh ? coarseEff : EXT_W'(fineSh);
    countNext = EXT_W'(count) + 1'b1;
  end

  always_comb begin
    strobe.advance = tick;
    strobe.wrap    = (countNext == periodVal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fineHit   <= 1'b0;
      coarseHit <= 1'b0;
    end else begin
      fineHit   <= tick && (countNext == fineEff);
      coarseHit <= tick && (countNext == coarseEff);
    end
  end

  always_comb begin
    inDuty  = (EXT_W'(count) < dutyVal);
    waveLvl = (inDuty ? activeHigh : ~activeHigh) ^ invertOut;
    pinEn   = (modeSel == MODE_PWM);
    pwmOut  = 1'b0;
    if (pinEn) begin
      case (outCtl)
        OUT_WAVE:             pwmOut = waveLvl;
        OUT_HIGH:             pwmOut = 1'b1;
        OUT_LOW, OUT_LOW_ALT: pwmOut = 1'b0;
        default:              pwmOut = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/swap_pwm_timer.sv
module swap_pwm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CRS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       outCtl,
  input  logic             activeHigh,
  input  logic             invertOut,
  input  logic             swapSel,
  input  logic [CRS_W-1:0] coarseReg,
  input  logic [CNT_W-1:0] fineReg,
  output logic             pwmOut,
  output logic             pinEn,
  output logic             fineHit,
  output logic             coarseHit
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] count;
  logic [CRS_W-1:0] coarseSh;
  logic [CNT_W-1:0] fineSh;
  logic             swapSh;

  tmr_datapath #(.CNT_W(CNT_W), .CRS_W(CRS_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .coarseIn(coarseReg), .fineIn(fineReg), .swapIn(swapSel),
    .count(count), .coarseSh(coarseSh), .fineSh(fineSh), .swapSh(swapSh)
  );

  tmr_control #(.CNT_W(CNT_W), .CRS_W(CRS_W)) u_ctl (
    .clk(clk), .rst(rst), .tick(tick), .modeSel(modeSel), .outCtl(outCtl),
    .activeHigh(activeHigh), .invertOut(invertOut),
    .count(count), .coarseSh(coarseSh), .fineSh(fineSh), .swapSh(swapSh),
    .strobe(strobe), .pwmOut(pwmOut), .pinEn(pinEn),
    .fineHit(fineHit), .coarseHit(coarseHit)
  );
endmodule

// File: rtl/swap_pwm_timer_chk.sv
module swap_pwm_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       modeSel,
  input logic [1:0]       outCtl,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] fineSh,
  input logic             pwmOut,
  input logic             pinEn,
  input logic             fineHit,
  input logic             coarseHit
);
  // R2: no tick, no movement
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R9: flags only follow a tick edge
  a_r9_fine_after_tick: assert property (@(posedge clk) disable iff (rst)
    fineHit |-> $past(tick));
  a_r9_coarse_after_tick: assert property (@(posedge clk) disable iff (rst)
    coarseHit |-> $past(tick));

  // R8: timer/counter mode leaves the pin alone
  a_r8_timer_pin_idle: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_TIMER) |-> (!pinEn && !pwmOut));

  // R7: forced high level
  a_r7_forced_high: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_PWM && outCtl == OUT_HIGH) |-> pwmOut);

  // R3/R4: every wrap coincides with the period register's flag
  a_r3_wrap_flags: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(tick) && count == '0 && $past(count) != '0)
      |-> (fineHit || coarseHit));

  // R10: shadow changes only where the count restarts
  a_r10_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && count != '0) |-> $stable(fineSh));
endmodule

bind swap_pwm_timer swap_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .modeSel(modeSel), .outCtl(outCtl),
  .count(count), .fineSh(fineSh), .pwmOut(pwmOut), .pinEn(pinEn),
  .fineHit(fineHit), .coarseHit(coarseHit)
);

// File: tb/test_swap_pwm_timer.sv
module test_swap_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [1:0] modeSel = 2'b10;
  logic [1:0] outCtl = 2'b10;
  logic activeHigh = 1'b1;
  logic invertOut = 1'b0;
  logic swapSel = 1'b0;
  logic [7:0] coarseReg = 8'd1;
  logic [15:0] fineReg = 16'd64;
  logic pwmOut, pinEn, fineHit, coarseHit;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swap_pwm_timer i_swap_pwm_timer (
    .clk(clk), .rst(rst), .tick(tick), .modeSel(modeSel), .outCtl(outCtl),
    .activeHigh(activeHigh), .invertOut(invertOut), .swapSel(swapSel),
    .coarseReg(coarseReg), .fineReg(fineReg),
    .pwmOut(pwmOut), .pinEn(pinEn), .fineHit(fineHit), .coarseHit(coarseHit)
  );

  typedef struct packed {
    logic        sw;
    logic [7:0]  co;
    logic [15:0] fi;
    logic        ah;
    logic        iv;
    logic [16:0] per;
    logic [16:0] hi;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd1, 16'd64,  1'b1, 1'b0, 17'd256, 17'd64},
    '{1'b0, 8'd2, 16'd128, 1'b1, 1'b0, 17'd512, 17'd128},
    '{1'b0, 8'd1, 16'd300, 1'b1, 1'b0, 17'd256, 17'd256},
    '{1'b0, 8'd1, 16'd0,   1'b1, 1'b0, 17'd256, 17'd0},
    '{1'b1, 8'd1, 16'd300, 1'b1, 1'b0, 17'd300, 17'd256},
    '{1'b1, 8'd0, 16'd200, 1'b1, 1'b0, 17'd200, 17'd200},
    '{1'b1, 8'd1, 16'd100, 1'b1, 1'b0, 17'd100, 17'd100},
    '{1'b0, 8'd1, 16'd64,  1'b0, 1'b0, 17'd256, 17'd192},
    '{1'b0, 8'd1, 16'd64,  1'b1, 1'b1, 17'd256, 17'd192},
    '{1'b0, 8'd1, 16'd64,  1'b0, 1'b1, 17'd256, 17'd64}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Load a configuration under reset, release at a falling edge
  task automatic startRun(input logic sw, input logic [7:0] co, input logic [15:0] fi,
                          input logic [1:0] md, input logic tk);
    @(negedge clk);
    rst = 1'b1; swapSel = sw; coarseReg = co; fineReg = fi;
    modeSel = md; outCtl = 2'b10; tick = tk;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runPeriod(input vec_t v);
    int highs;
    int first;
    startRun(v.sw, v.co, v.fi, 2'b10, 1'b1);
    activeHigh = v.ah; invertOut = v.iv;
    #1;
    highs = int'(pwmOut);
    first = 0;
    for (int i = 1; i <= int'(v.per); i++) begin
      @(negedge clk);
      if (i < int'(v.per)) highs += int'(pwmOut);
      if ((v.sw ? fineHit : coarseHit) && first == 0) first = i;
    end
    if (v.sw) check("R4", "period", first, int'(v.per));
    else      check("R3", "period", first, int'(v.per));
    if (v.ah && !v.iv) check("R5", "active counts", highs, int'(v.hi));
    else               check("R6", "high counts", highs, int'(v.hi));
    activeHigh = 1'b1; invertOut = 1'b0;
  endtask

  initial begin
    vec_t full;
    int firstF, firstC, nF, highs, f1, f2, bad;

    // R1: reset holds count at 0 even with ticks
    @(negedge clk);
    rst = 1'b1; swapSel = 1'b0; coarseReg = 8'd1; fineReg = 16'd1; tick = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "fineHit in reset", int'(fineHit), 0);
    check("R1", "coarseHit in reset", int'(coarseHit), 0);
    check("R1", "pwm at count 0", int'(pwmOut), 1);

    // Table walk: R3..R6
    foreach (VECS[k]) runPeriod(VECS[k]);

    // R3: coarse 0 gives 65536 counts
    full = '{1'b0, 8'd0, 16'd1000, 1'b1, 1'b0, 17'd65536, 17'd1000};
    runPeriod(full);

    // R2/R9: tick on every third clock, fine match after fifth tick
    startRun(1'b0, 8'd1, 16'd5, 2'b10, 1'b0);
    firstF = 0; nF = 0;
    for (int j = 0; j < 18; j++) begin
      tick = ((j + 1) % 3 == 0);
      @(negedge clk);
      if (fineHit) begin nF++; if (firstF == 0) firstF = j + 1; end
    end
    check("R2", "clock of fine match with sparse ticks", firstF, 15);
    check("R9", "fine pulse width", nF, 1);
    tick = 1'b1;

    // R9: both flags when fine sets the period
    startRun(1'b1, 8'd1, 16'd300, 2'b10, 1'b1);
    firstF = 0; firstC = 0; nF = 0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (fineHit) begin nF++; if (firstF == 0) firstF = i; end
      if (coarseHit && firstC == 0) firstC = i;
    end
    check("R9", "coarse match clock", firstC, 256);
    check("R9", "fine match clock", firstF, 300);
    check("R9", "fine pulse count", nF, 1);

    // R7: output control in PWM mode
    startRun(1'b0, 8'd1, 16'd64, 2'b10, 1'b1);
    repeat (10) @(negedge clk);
    check("R7", "pinEn", int'(pinEn), 1);
    outCtl = 2'b00; #1; check("R7", "force low 00", int'(pwmOut), 0);
    outCtl = 2'b11; #1; check("R7", "force low 11", int'(pwmOut), 0);
    outCtl = 2'b10; #1; check("R7", "wave inside duty", int'(pwmOut), 1);
    repeat (90) @(negedge clk);
    outCtl = 2'b01; #1; check("R7", "force high", int'(pwmOut), 1);
    outCtl = 2'b10; #1; check("R7", "wave past duty", int'(pwmOut), 0);

    // R8: timer/counter mode
    startRun(1'b0, 8'd1, 16'd10, 2'b11, 1'b1);
    firstF = 0; firstC = 0; bad = 0;
    for (int i = 1; i <= 256; i++) begin
      @(negedge clk);
      if (pwmOut || pinEn) bad++;
      if (fineHit && firstF == 0) firstF = i;
      if (coarseHit && firstC == 0) firstC = i;
    end
    check("R8", "pin activity in timer mode", bad, 0);
    check("R8", "fine match in timer mode", firstF, 10);
    check("R8", "coarse match in timer mode", firstC, 256);
    modeSel = 2'b00; #1;
    check("R8", "pinEn in mode 00", int'(pinEn), 0);

    // R10: register change mid-period waits for the wrap
    startRun(1'b0, 8'd1, 16'd64, 2'b10, 1'b1);
    f1 = 0; f2 = 0; highs = 0; bad = 0;
    for (int i = 1; i <= 768; i++) begin
      @(negedge clk);
      if (i > 100 && i < 256 && pwmOut) bad++;
      if (i >= 256 && i < 768) highs += int'(pwmOut);
      if (coarseHit) begin if (f1 == 0) f1 = i; else if (f2 == 0) f2 = i; end
      if (i == 100) begin fineReg = 16'd200; coarseReg = 8'd2; end
    end
    check("R10", "old duty kept after write", bad, 0);
    check("R10", "old period end", f1, 256);
    check("R10", "new period end", f2, 768);
    check("R10", "new duty counts", highs, 200);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule